// File: doc/BRIEF.md
# Three-Wire Serial Gamma Register File

This block is the digital front end of a gamma reference generator. A host writes it through a three-line serial port: a serial clock, a serial data line and a latch strobe. Each write frame carries a register address, three option bits and a 10-bit voltage code. The block holds twelve 10-bit gamma channel codes and one 10-bit control code. It presents all of them in parallel to the downstream converter and refresh logic.

The serial lines are asynchronous to the system clock. Each line passes through a two-stage synchronizer, and the block finds the serial-clock and latch edges by oversampling. While the latch is low, the block shifts in one data bit on each serial-clock rising edge, most significant bit first. On the rising edge of the latch it checks the frame. It commits the frame only if exactly 17 bits arrived and the address is valid. A complete write is 17 data clocks plus one clock with the latch held high, so 18 serial clocks in all. Updating every channel takes twelve frames.

Writes to address 12 load the control code. They also take one option bit that selects the external refresh oscillator. The amplifier-source output goes high when the external level input is high. It also goes high when the control code equals the reserved value 2A0h.

Top module: `gamma_serial_regfile`

## Requirements
- R1: Synchronous reset clears all twelve channel codes, the control code and the oscillator select to zero.
- R2: A frame is 17 bits sent MSB first. Bits 16..13 are the address, bits 12..10 are option bits and bits 9..0 are the code. A valid frame to address 0..11 loads that channel with the code.
- R3: A committed frame changes at most one channel, and leaves every other channel unchanged.
- R4: A frame with more or fewer than 17 data bits is discarded, and no register changes.
- R5: A frame addressed to 13, 14 or 15 is discarded, and no register changes.
- R6: A valid frame to address 12 loads the control code with the frame's code.
- R7: A valid frame to address 12 sets the oscillator select from frame bit 10, where 1 means external. Frames to other addresses leave it unchanged.
- R8: The amplifier-source output is 1 when the level input is 1 or the control code is 2A0h, and 0 otherwise.
- R9: Serial-clock edges while the latch is high are not counted or shifted.
- R10: A committed value appears at the outputs within 5 system clocks after the latch line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on ser_clk rise |
| ser_latch | input | 1 | Frame strobe; low while shifting, rising edge commits |
| ctl | input | 1 | Level input forcing the amplifier source to the converter |
| gamma_flat | output | 120 | Twelve 10-bit channel codes, channel 0 in the low bits |
| ctrl_code | output | 10 | Control register code |
| osc_ext | output | 1 | 1 selects the external refresh oscillator |
| source_dac | output | 1 | 1 routes amplifier inputs to converter outputs |

## Verification
A wrong bit counter or a shift register that is off by one shows up at the ports as a misplaced code. It can also show up as a frame that wrongly commits or is wrongly dropped, and this is visible a few clocks after the next latch rise. A decode fault writes a neighbouring channel or the control code instead of the addressed one, so every sweep step compares all thirteen registers. A corrupted control code appears at once on the amplifier-source output, because that output follows the code combinationally.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    localparam int NUM_CH     = 12;
    localparam int DATA_W     = 10;
    localparam int ADDR_W     = 4;
    localparam int OPT_W      = 3;
    localparam int FRAME_BITS = ADDR_W + OPT_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CNT_SAT    = FRAME_BITS + 1;
    localparam int CTRL_ADDR  = NUM_CH;
    localparam int OSC_OPT    = 0;
    localparam int BANK_W     = NUM_CH * DATA_W;
    localparam int SYNC_STAGES = 2;

    localparam logic [DATA_W-1:0] SRC_DAC_CODE = DATA_W'(10'h2A0);

    typedef logic [DATA_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t             addr;
        logic [OPT_W-1:0]  opt;
        code_t             code;
    } frame_t;

    typedef struct packed {
        logic clk_rise;
        logic latch_rise;
        logic latch_lvl;
        logic data_lvl;
    } ser_evt_t;

    function automatic logic is_channel(input addr_t a);
        return int'(a) < NUM_CH;
    endfunction

    function automatic logic is_ctrl(input addr_t a);
        return int'(a) == CTRL_ADDR;
    endfunction

endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d};
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gsr_front.sv
module gsr_front
    import gsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     ser_data,
    input  logic     ser_latch,
    output ser_evt_t evt
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] syn;
    logic             clk_d;
    logic             latch_d;

    assign raw = {ser_latch, ser_data, ser_clk};

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_sync
            gsr_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk (clk),
                .rst (rst),
                .d   (raw[i]),
                .q   (syn[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d   <= 1'b0;
            latch_d <= 1'b0;
        end else begin
            clk_d   <= syn[0];
            latch_d <= syn[2];
        end
    end

    always_comb begin
        evt.clk_rise   = syn[0] & ~clk_d;
        evt.latch_rise = syn[2] & ~latch_d;
        evt.latch_lvl  = syn[2];
        evt.data_lvl   = syn[1];
    end
endmodule

// File: rtl/gsr_shifter.sv
module gsr_shifter
    import gsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t evt,
    output logic     frame_ok,
    output addr_t    frame_addr,
    output code_t    frame_code,
    output logic     frame_osc
);
    logic [FRAME_BITS-1:0] sreg;
    logic [CNT_W-1:0]      cnt;
    frame_t                held;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg     <= '0;
            cnt      <= '0;
            frame_ok <= 1'b0;
            held     <= '0;
        end else begin
            frame_ok <= 1'b0;
            if (evt.latch_rise) begin
                frame_ok <= (cnt == CNT_W'(FRAME_BITS));
                held     <= frame_t'(sreg);
                cnt      <= '0;
            end else if (evt.latch_lvl) begin
                cnt <= '0;
            end else if (evt.clk_rise) begin
                sreg <= {sreg[FRAME_BITS-2:0], evt.data_lvl};
                if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_addr = held.addr;
    assign frame_code = held.code;
    assign frame_osc  = held.opt[OSC_OPT];
endmodule

// File: rtl/gsr_bank.sv
module gsr_bank
    import gsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_ok,
    input  addr_t             frame_addr,
    input  code_t             frame_code,
    input  logic              frame_osc,
    output logic [BANK_W-1:0] gamma_flat,
    output code_t             ctrl_code,
    output logic              osc_ext
);
    code_t ch_q [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic wr_en;
            assign wr_en = frame_ok && is_channel(frame_addr) &&
                           (frame_addr == ADDR_W'(c));
            always_ff @(posedge clk) begin
                if (rst)        ch_q[c] <= '0;
                else if (wr_en) ch_q[c] <= frame_code;
            end
            assign gamma_flat[c*DATA_W +: DATA_W] = ch_q[c];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_code <= '0;
            osc_ext   <= 1'b0;
        end else if (frame_ok && is_ctrl(frame_addr)) begin
            ctrl_code <= frame_code;
            osc_ext   <= frame_osc;
        end
    end
endmodule

// File: rtl/gamma_serial_regfile.sv
module gamma_serial_regfile
    import gsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    input  logic              ctl,
    output logic [BANK_W-1:0] gamma_flat,
    output logic [DATA_W-1:0] ctrl_code,
    output logic              osc_ext,
    output logic              source_dac
);
    ser_evt_t evt;
    logic     frame_ok;
    addr_t    frame_addr;
    code_t    frame_code;
    logic     frame_osc;

    gsr_front front_i (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .evt       (evt)
    );

    gsr_shifter shift_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .frame_ok   (frame_ok),
        .frame_addr (frame_addr),
        .frame_code (frame_code),
        .frame_osc  (frame_osc)
    );

    gsr_bank bank_i (
        .clk        (clk),
        .rst        (rst),
        .frame_ok   (frame_ok),
        .frame_addr (frame_addr),
        .frame_code (frame_code),
        .frame_osc  (frame_osc),
        .gamma_flat (gamma_flat),
        .ctrl_code  (ctrl_code),
        .osc_ext    (osc_ext)
    );

    assign source_dac = ctl | (ctrl_code == SRC_DAC_CODE);
endmodule

// File: rtl/gsr_regfile_chk.sv
module gsr_regfile_chk
    import gsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl,
    input logic              frame_ok,
    input addr_t             frame_addr,
    input logic [BANK_W-1:0] gamma_flat,
    input code_t             ctrl_code,
    input logic              osc_ext,
    input logic              source_dac
);
    logic [BANK_W-1:0] prev;
    logic              prev_v;
    logic [NUM_CH-1:0] chg;

    always_ff @(posedge clk) begin
        prev   <= gamma_flat;
        prev_v <= !rst;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            chg[i] = prev[i*DATA_W +: DATA_W] != gamma_flat[i*DATA_W +: DATA_W];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (gamma_flat == '0 && ctrl_code == '0 && !osc_ext));

    // R3
    one_channel_chk: assert property (@(posedge clk) disable iff (rst)
        prev_v |-> $countones(chg) <= 1);

    // R4
    no_frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_ok |=> ($stable(gamma_flat) && $stable(ctrl_code)));

    // R5
    bad_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && int'(frame_addr) > CTRL_ADDR) |=>
            ($stable(gamma_flat) && $stable(ctrl_code) && $stable(osc_ext)));

    // R7
    osc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_ok || int'(frame_addr) != CTRL_ADDR) |=> $stable(osc_ext));

    // R8
    src_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_code == SRC_DAC_CODE || ctl) |-> source_dac);
endmodule

bind gamma_serial_regfile gsr_regfile_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .frame_ok   (frame_ok),
    .frame_addr (frame_addr),
    .gamma_flat (gamma_flat),
    .ctrl_code  (ctrl_code),
    .osc_ext    (osc_ext),
    .source_dac (source_dac)
);

// File: tb/gamma_serial_regfile_tb_top.sv
module gamma_serial_regfile_tb_top;
    localparam int NCH = 12;
    localparam int DW  = 10;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_latch = 1'b1;
    logic ctl = 1'b0;
    logic [NCH*DW-1:0] gamma_flat;
    logic [DW-1:0]     ctrl_code;
    logic              osc_ext;
    logic              source_dac;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [DW-1:0] exp_g [NCH];
    logic [DW-1:0] exp_ctrl;
    logic          exp_osc;

    always #2 clk = ~clk;

    gamma_serial_regfile dut_i (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_latch  (ser_latch),
        .ctl        (ctl),
        .gamma_flat (gamma_flat),
        .ctrl_code  (ctrl_code),
        .osc_ext    (osc_ext),
        .source_dac (source_dac)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++)
            check(gamma_flat[c*DW +: DW] == exp_g[c], req,
                  int'(gamma_flat[c*DW +: DW]), int'(exp_g[c]));
        check(ctrl_code == exp_ctrl, req, int'(ctrl_code), int'(exp_ctrl));
        check(osc_ext == exp_osc, req, int'(osc_ext), int'(exp_osc));
        check(source_dac == (ctl || exp_ctrl == 10'h2A0), req,
              int'(source_dac), int'(ctl || exp_ctrl == 10'h2A0));
    endtask

    task automatic shift_n(input logic [31:0] w, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            ser_data = w[b];
            wait_cyc(HALF);
            ser_clk = 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b0;
        end
    endtask

    task automatic latch_tail();
        wait_cyc(HALF);
        ser_clk = 1'b1;
        wait_cyc(HALF);
        ser_clk = 1'b0;
        wait_cyc(HALF);
        ser_latch = 1'b0;
        wait_cyc(HALF);
    endtask

    function automatic logic [16:0] mk(input int a, input int opt, input int d);
        return {4'(a), 3'(opt), 10'(d)};
    endfunction

    task automatic send(input logic [31:0] w, input int n);
        shift_n(w, n);
        wait_cyc(HALF);
        ser_latch = 1'b1;
        wait_cyc(6);
        latch_tail();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) exp_g[c] = '0;
        exp_ctrl = '0;
        exp_osc  = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        ser_latch = 1'b0;
        wait_cyc(HALF);
        check_all("R1 reset");

        // R2 R3: two full sweeps, every register compared after each write
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < NCH; c++) begin
                int v;
                v = ((c * 83 + 17) % 1024) ^ (pass * 10'h3FF);
                send(mk(c, 0, v), 17);
                exp_g[c] = 10'(v);
                check_all("R2 R3 channel write");
            end
        end

        // R5: out-of-range addresses
        for (int a = 13; a < 16; a++) begin
            send(mk(a, 1, 10'h155), 17);
            check_all("R5 bad address");
        end

        // R4: short and long frames
        send(32'(mk(5, 0, 10'h0AA)) >> 1, 16);
        check_all("R4 short frame");
        send({mk(5, 0, 10'h0AA), 1'b0}, 18);
        check_all("R4 long frame");
        send(32'(mk(6, 0, 10'h3C3)), 1);
        check_all("R4 one bit");

        // R9: extra clock pulses while latch high are not counted
        ser_latch = 1'b1;
        wait_cyc(HALF);
        for (int k = 0; k < 3; k++) begin
            ser_clk = 1'b1; wait_cyc(HALF);
            ser_clk = 1'b0; wait_cyc(HALF);
        end
        ser_latch = 1'b0;
        wait_cyc(HALF);
        send(mk(7, 0, 10'h2B4), 17);
        exp_g[7] = 10'h2B4;
        check_all("R9 clocks during latch");

        // R10: latency after latch rise
        shift_n(32'(mk(3, 0, 10'h111)), 17);
        wait_cyc(HALF);
        ser_latch = 1'b1;
        wait_cyc(5);
        check(gamma_flat[3*DW +: DW] == 10'h111, "R10 latency",
              int'(gamma_flat[3*DW +: DW]), 10'h111);
        exp_g[3] = 10'h111;
        latch_tail();

        // R6 R7 R8: control register
        send(mk(12, 1, 10'h2A0), 17);
        exp_ctrl = 10'h2A0; exp_osc = 1'b1;
        check_all("R6 R7 R8 ctrl 2A0");
        check(source_dac == 1'b1, "R8 code forces source", int'(source_dac), 1);
        send(mk(12, 6, 10'h2A1), 17);
        exp_ctrl = 10'h2A1; exp_osc = 1'b0;
        check_all("R6 R7 ctrl 2A1");
        check(source_dac == 1'b0, "R8 near code", int'(source_dac), 0);
        ctl = 1'b1; wait_cyc(1);
        check(source_dac == 1'b1, "R8 ctl high", int'(source_dac), 1);
        ctl = 1'b0; wait_cyc(1);
        check(source_dac == 1'b0, "R8 ctl low", int'(source_dac), 0);
        send(mk(2, 1, 10'h2A0), 17);
        exp_g[2] = 10'h2A0;
        check_all("R7 osc kept on channel write");
        check(source_dac == 1'b0, "R8 channel code no effect", int'(source_dac), 0);

        // R1: reset in mid-run
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) exp_g[c] = '0;
        exp_ctrl = '0; exp_osc = 1'b0;
        wait_cyc(1);
        check_all("R1 reset after writes");

        done = 1;
        finish_run();
    end
endmodule